// File: doc/BRIEF.md
# Multi-Mode Three-Axis Sample Buffer

This block sits behind a motion-sensor front end and holds three-axis samples (one X, one Y and one Z signed word, captured together as one entry) so that a host can stay asleep and later drain a burst. A two-bit mode input picks the write policy. The block can be a single pass-through slot with no storage, a queue that stops when it fills, a ring that overwrites its oldest entry, or a ring that turns into a stop-when-full queue once a trigger arrives.

The fill level drives threshold, empty and full events. Each event has its own enable and its own choice of interrupt pin, and both pins are level outputs. Each read strobe pops one entry into a registered read-data port. Changing the mode empties the buffer.

Top module: `tri_axis_fifo`

## Requirements
- R1: Mode encoding is 0 = pass-through, 1 = stop-when-full queue, 2 = overwrite ring, 3 = triggered ring. After reset the mode register is 0, the level is 0, `flag_empty` is 1, `flag_overrun` is 0 and the read data is 0.
- R2: In mode 0 the level stays 0. A sample strobe places that sample on the read-data ports one cycle later. A read strobe changes nothing.
- R3: In mode 1 each sample is appended while the level is below 32. With 32 entries stored and no read in the same cycle, a new sample is discarded and the stored contents are unchanged.
- R4: In mode 2 a sample arriving at level 32 with no read drops the oldest entry, keeps the newest 32 and sets `flag_overrun`, which stays set until a mode change or reset.
- R5: In mode 3 the buffer overwrites like mode 2 until `trig` has been seen high. From the following cycle onward it discards samples at level 32 like mode 1.
- R6: A read strobe with a non-zero level pops the oldest entry onto the read-data ports one cycle later and decrements the level. A read strobe at level 0 leaves the data and the level unchanged.
- R7: A sample strobe and a read strobe in the same cycle at non-zero level leave the level unchanged. This holds at level 32 in every storing mode.
- R8: In the cycle after `mode` differs from the registered mode, the level is 0 and `flag_overrun` is 0. Samples and reads in that cycle are ignored, and the trigger latch is cleared.
- R9: `flag_thr` is high while the level is greater than or equal to `thresh`. `flag_empty` is high at level 0 and `flag_full` is high at level 32.
- R10: Event bit 0 is threshold, bit 1 is empty and bit 2 is full. An event drives `int1` when its `irq_en` bit is 1 and its `irq_sel` bit is 0, and drives `int2` when its `irq_en` bit is 1 and its `irq_sel` bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | New three-axis sample present |
| smp_x | input | 16 | X sample, signed |
| smp_y | input | 16 | Y sample, signed |
| smp_z | input | 16 | Z sample, signed |
| rd_en | input | 1 | Pop one entry |
| mode | input | 2 | Write policy select |
| thresh | input | 6 | Threshold level, 0 to 32 |
| irq_en | input | 3 | Event enables: threshold, empty, full |
| irq_sel | input | 3 | Event pin choice, 0 = int1, 1 = int2 |
| trig | input | 1 | Switches mode 3 to stop-when-full |
| rd_x | output | 16 | Read data X |
| rd_y | output | 16 | Read data Y |
| rd_z | output | 16 | Read data Z |
| level | output | 6 | Stored entry count, 0 to 32 |
| flag_thr | output | 1 | Level at or above threshold |
| flag_empty | output | 1 | Level is 0 |
| flag_full | output | 1 | Level is 32 |
| flag_overrun | output | 1 | An entry was overwritten since the last flush |
| int1 | output | 1 | Interrupt pin 1 |
| int2 | output | 1 | Interrupt pin 2 |

## Verification
A read pointer that drifts from the write pointer first shows on the read-data ports, on the first pop after the drift. A write-policy slip can go unseen on the level port, because the level reads 32 in every storing mode. It shows only when the next pop returns the frozen first entry or the surviving third entry, so the bench pops right after each overfill. A level counter error shows within one cycle, on `level` and on the three flags and both interrupt pins.

// File: rtl/tfifo_pkg.sv
package tfifo_pkg;
    localparam int AXIS_W = 16;

    typedef enum logic [1:0] {
        MODE_PASS      = 2'd0,
        MODE_QUEUE     = 2'd1,
        MODE_RING      = 2'd2,
        MODE_TRIGGERED = 2'd3
    } fifo_mode_e;

    typedef struct packed {
        logic signed [AXIS_W-1:0] x;
        logic signed [AXIS_W-1:0] y;
        logic signed [AXIS_W-1:0] z;
    } triple_t;

    localparam int EV_THR   = 0;
    localparam int EV_EMPTY = 1;
    localparam int EV_FULL  = 2;
    localparam int EV_N     = 3;

    // true when the active policy discards samples at full level
    function automatic logic halts_at_full(fifo_mode_e m, logic trig_latched);
        return (m == MODE_QUEUE) || ((m == MODE_TRIGGERED) && trig_latched);
    endfunction
endpackage

// File: rtl/tfifo_store.sv
module tfifo_store
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [PTR_W-1:0] waddr,
    input  triple_t          wdata,
    input  logic [PTR_W-1:0] raddr,
    output triple_t          rdata
);
    triple_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/tfifo_ctrl.sv
module tfifo_ctrl
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  fifo_mode_e       mode_in,
    input  logic             smp_valid,
    input  logic             rd_en,
    input  logic             trig,
    output fifo_mode_e       mode_q,
    output logic             pass_capture,
    output logic             push,
    output logic             pop,
    output logic [PTR_W-1:0] wptr,
    output logic [PTR_W-1:0] rptr,
    output logic [CNT_W-1:0] count,
    output logic             overrun
);
    logic mode_chg, storing, full, drop, trig_seen;
    logic [CNT_W-1:0] count_nx;

    function automatic logic [PTR_W-1:0] bump(logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        mode_chg     = (mode_in != mode_q);
        storing      = !mode_chg && (mode_q != MODE_PASS);
        pass_capture = !mode_chg && (mode_q == MODE_PASS) && smp_valid;
        full         = (count == CNT_W'(DEPTH));
        pop          = storing && rd_en && (count != '0);
        push         = storing && smp_valid && (!full || pop || !halts_at_full(mode_q, trig_seen));
        drop         = push && full && !pop;
        count_nx     = count + CNT_W'(push) - CNT_W'(pop | drop);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q    <= MODE_PASS;
            wptr      <= '0;
            rptr      <= '0;
            count     <= '0;
            overrun   <= 1'b0;
            trig_seen <= 1'b0;
        end else if (mode_chg) begin
            mode_q    <= mode_in;
            wptr      <= '0;
            rptr      <= '0;
            count     <= '0;
            overrun   <= 1'b0;
            trig_seen <= 1'b0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop || drop) rptr <= bump(rptr);
            count <= count_nx;
            if (drop) overrun <= 1'b1;
            if (mode_q == MODE_TRIGGERED && trig) trig_seen <= 1'b1;
        end
    end

    assert_level_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    assert_pass_empty_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_PASS) |-> (count == '0));

    assert_queue_freeze_R3: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_QUEUE && mode_in == mode_q && count == CNT_W'(DEPTH) && !rd_en)
        |=> ($stable(rptr) && $stable(wptr) && count == CNT_W'(DEPTH)));

    assert_ring_overrun_R4: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_RING && mode_in == mode_q && count == CNT_W'(DEPTH) && smp_valid && !rd_en)
        |=> (overrun && count == CNT_W'(DEPTH)));

    assert_flush_R8: assert property (@(posedge clk) disable iff (rst)
        (mode_in != mode_q) |=> (count == '0 && !overrun));

    assert_rw_balance_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_in == mode_q && mode_q != MODE_PASS && smp_valid && rd_en && count != '0)
        |=> $stable(count));
endmodule

// File: rtl/tfifo_irq.sv
module tfifo_irq
    import tfifo_pkg::*;
(
    input  logic [EV_N-1:0] events,
    input  logic [EV_N-1:0] enable,
    input  logic [EV_N-1:0] route,
    output logic            int1,
    output logic            int2
);
    logic [EV_N-1:0] to1, to2;

    for (genvar i = 0; i < EV_N; i++) begin : g_route
        assign to1[i] = events[i] & enable[i] & ~route[i];
        assign to2[i] = events[i] & enable[i] &  route[i];
    end

    assign int1 = |to1;
    assign int2 = |to2;
endmodule

// File: rtl/tri_axis_fifo.sv
module tri_axis_fifo
    import tfifo_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     smp_valid,
    input  logic signed [AXIS_W-1:0] smp_x,
    input  logic signed [AXIS_W-1:0] smp_y,
    input  logic signed [AXIS_W-1:0] smp_z,
    input  logic                     rd_en,
    input  logic [1:0]               mode,
    input  logic [CNT_W-1:0]         thresh,
    input  logic [EV_N-1:0]          irq_en,
    input  logic [EV_N-1:0]          irq_sel,
    input  logic                     trig,
    output logic signed [AXIS_W-1:0] rd_x,
    output logic signed [AXIS_W-1:0] rd_y,
    output logic signed [AXIS_W-1:0] rd_z,
    output logic [CNT_W-1:0]         level,
    output logic                     flag_thr,
    output logic                     flag_empty,
    output logic                     flag_full,
    output logic                     flag_overrun,
    output logic                     int1,
    output logic                     int2
);
    fifo_mode_e       mode_q;
    logic             pass_capture, push, pop;
    logic [PTR_W-1:0] wptr, rptr;
    logic [CNT_W-1:0] count;
    triple_t          in_word, head_word, out_q;
    logic [EV_N-1:0]  events;

    assign in_word = '{x: smp_x, y: smp_y, z: smp_z};

    tfifo_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk(clk), .rst(rst), .mode_in(fifo_mode_e'(mode)),
        .smp_valid(smp_valid), .rd_en(rd_en), .trig(trig),
        .mode_q(mode_q), .pass_capture(pass_capture), .push(push), .pop(pop),
        .wptr(wptr), .rptr(rptr), .count(count), .overrun(flag_overrun)
    );

    tfifo_store #(.DEPTH(DEPTH)) i_store (
        .clk(clk), .we(push), .waddr(wptr), .wdata(in_word),
        .raddr(rptr), .rdata(head_word)
    );

    always_ff @(posedge clk) begin
        if (rst)               out_q <= '0;
        else if (pass_capture) out_q <= in_word;
        else if (pop)          out_q <= head_word;
    end

    assign rd_x = out_q.x;
    assign rd_y = out_q.y;
    assign rd_z = out_q.z;

    assign level      = count;
    assign flag_empty = (count == '0);
    assign flag_full  = (count == CNT_W'(DEPTH));
    assign flag_thr   = (count >= thresh);

    assign events[EV_THR]   = flag_thr;
    assign events[EV_EMPTY] = flag_empty;
    assign events[EV_FULL]  = flag_full;

    tfifo_irq i_irq (
        .events(events), .enable(irq_en), .route(irq_sel),
        .int1(int1), .int2(int2)
    );

    assert_empty_read_R6: assert property (@(posedge clk) disable iff (rst)
        (level == '0 && rd_en && !smp_valid) |=> ($stable(rd_x) && $stable(level)));

    assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> (!int1 && !int2));

    assert_pins_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
        ((irq_en & irq_sel) == '0) |-> !int2);
endmodule

// File: tb/test_tri_axis_fifo.sv
`timescale 1ns/1ps
module test_tri_axis_fifo;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic smp_valid = 1'b0, rd_en = 1'b0, trig = 1'b0;
    logic signed [15:0] smp_x = '0, smp_y = '0, smp_z = '0;
    logic [1:0] mode = 2'd0;
    logic [5:0] thresh = 6'd40;
    logic [2:0] irq_en = 3'b000, irq_sel = 3'b000;
    logic signed [15:0] rd_x, rd_y, rd_z;
    logic [5:0] level;
    logic flag_thr, flag_empty, flag_full, flag_overrun, int1, int2;

    int nvec = 0;
    int nerr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    tri_axis_fifo i_tri_axis_fifo (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_x(smp_x), .smp_y(smp_y),
        .smp_z(smp_z), .rd_en(rd_en), .mode(mode), .thresh(thresh), .irq_en(irq_en),
        .irq_sel(irq_sel), .trig(trig), .rd_x(rd_x), .rd_y(rd_y), .rd_z(rd_z),
        .level(level), .flag_thr(flag_thr), .flag_empty(flag_empty),
        .flag_full(flag_full), .flag_overrun(flag_overrun), .int1(int1), .int2(int2)
    );

    // {mode, valid, read, x, expected level, expected rd_x}
    localparam int NV = 11;
    localparam logic [41:0] VEC [NV] = '{
        {2'd1, 1'b0, 1'b0, 16'd0,  6'd0, 16'd0},   // R8 flush cycle into queue mode
        {2'd1, 1'b1, 1'b0, 16'd10, 6'd1, 16'd0},   // R3 append
        {2'd1, 1'b1, 1'b0, 16'd20, 6'd2, 16'd0},   // R3 append
        {2'd1, 1'b0, 1'b1, 16'd0,  6'd1, 16'd10},  // R6 pop oldest
        {2'd1, 1'b1, 1'b1, 16'd30, 6'd1, 16'd20},  // R7 write and read together
        {2'd1, 1'b0, 1'b1, 16'd0,  6'd0, 16'd30},  // R6 pop last
        {2'd1, 1'b0, 1'b1, 16'd0,  6'd0, 16'd30},  // R6 empty read
        {2'd0, 1'b1, 1'b0, 16'd40, 6'd0, 16'd30},  // R8 sample ignored on change
        {2'd0, 1'b1, 1'b0, 16'd50, 6'd0, 16'd50},  // R2 pass-through
        {2'd0, 1'b1, 1'b0, 16'd60, 6'd0, 16'd60},  // R2 latest sample
        {2'd0, 1'b0, 1'b1, 16'd0,  6'd0, 16'd60}   // R2 read has no effect
    };

    task automatic check(input string req, input int act, input int exp);
        nvec++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // drive one cycle of stimulus from a falling edge; returns at the next falling edge
    task automatic cyc(input logic v, input int d, input logic r, input logic t);
        smp_valid = v; smp_x = 16'(d); smp_y = 16'(d + 100); smp_z = 16'(-d);
        rd_en = r; trig = t;
        @(negedge clk);
        smp_valid = 1'b0; rd_en = 1'b0; trig = 1'b0;
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode = m;
        cyc(1'b0, 0, 1'b0, 1'b0);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 level", level, 0);
        check("R1 empty", flag_empty, 1);
        check("R1 overrun", flag_overrun, 0);
        check("R1 rd_x", rd_x, 0);

        for (int i = 0; i < NV; i++) begin
            mode = VEC[i][41:40];
            cyc(VEC[i][39], int'(signed'(VEC[i][37:22])), VEC[i][38], 1'b0);
            check($sformatf("vector %0d level", i), level, int'(VEC[i][21:16]));
            check($sformatf("vector %0d rd_x", i), rd_x, int'(VEC[i][15:0]));
        end
        check("R2 rd_y", rd_y, 160);
        check("R2 rd_z", rd_z, -60);

        // R3 queue: fill beyond capacity, first entry survives
        set_mode(2'd1);
        for (int v = 1; v <= 33; v++) cyc(1'b1, v, 1'b0, 1'b0);
        check("R3 level full", level, 32);
        check("R9 full flag", flag_full, 1);
        cyc(1'b1, 77, 1'b1, 1'b0);
        check("R7 level at full", level, 32);
        check("R3 first kept", rd_x, 1);
        cyc(1'b0, 0, 1'b1, 1'b0);
        check("R3 second entry", rd_x, 2);
        check("R3 second y", rd_y, 102);

        // R8 flush on mode change
        set_mode(2'd2);
        check("R8 level cleared", level, 0);

        // R4 ring: oldest two dropped
        for (int v = 1; v <= 34; v++) cyc(1'b1, v, 1'b0, 1'b0);
        check("R4 level", level, 32);
        check("R4 overrun", flag_overrun, 1);
        cyc(1'b0, 0, 1'b1, 1'b0);
        check("R4 oldest surviving", rd_x, 3);
        check("R4 overrun sticky", flag_overrun, 1);
        set_mode(2'd3);
        check("R8 overrun cleared", flag_overrun, 0);

        // R5 triggered ring
        for (int v = 1; v <= 34; v++) cyc(1'b1, v, 1'b0, 1'b0);
        cyc(1'b1, 35, 1'b0, 1'b1);
        cyc(1'b1, 36, 1'b0, 1'b0);
        check("R5 level", level, 32);
        cyc(1'b0, 0, 1'b1, 1'b0);
        check("R5 oldest after trigger", rd_x, 4);
        check("R5 level after pop", level, 31);

        // R9 R10 threshold and routing
        thresh = 6'd3; irq_en = 3'b111; irq_sel = 3'b001;
        set_mode(2'd1);
        check("R10 empty on int1", int1, 1);
        check("R10 int2 low", int2, 0);
        check("R9 thr low", flag_thr, 0);
        for (int v = 1; v <= 3; v++) cyc(1'b1, v, 1'b0, 1'b0);
        check("R9 thr at level", flag_thr, 1);
        check("R10 thr on int2", int2, 1);
        check("R10 int1 low", int1, 0);
        for (int v = 4; v <= 32; v++) cyc(1'b1, v, 1'b0, 1'b0);
        check("R10 full on int1", int1, 1);
        irq_en = 3'b011;
        #1;
        check("R10 full masked", int1, 0);
        irq_sel = 3'b100; irq_en = 3'b100;
        #1;
        check("R10 full on int2", int2, 1);
        check("R10 int1 unrouted", int1, 0);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end
endmodule